// File: doc/BRIEF.md
# Integer ALU with Registered Condition Flags

This block is the integer execute datapath of a small processor core. It takes two operands and an operation code, and in the same cycle it produces a result, a write-back enable for the destination register, and the next value of four condition flags: negative (N), zero (Z), carry (C) and overflow (V). The flags sit in a register inside the block. That register loads the next value on a rising clock edge when the flag-write input is high, and it is presented at its own output, so branch logic can test it.

One shared adder handles all the arithmetic. Subtraction adds the inverted second operand plus one, so the carry flag means "no borrow" on subtract-type operations. Subtract-with-carry uses the current carry in place of the plus-one. Compare, compare-negative and test compute flags in the normal way, but they drop the write-back. Logical operations refresh N and Z and carry C and V through unchanged. Operand width is a parameter with a default of 32.

Top module: `alu_flags_unit`

## Requirements
- R1: Opcodes 0 (add), 1 (add with carry) and 6 (compare-negative) form A + B, with the current C added for opcode 1. C is set when the sum carries out of the top bit. Example: 0x80000000 + 0x80000000 gives 0 with C = 1.
- R2: Opcodes 2 (subtract), 5 (compare), 3 (subtract with carry) and 4 (negate) behave as follows. Opcodes 2 and 5 form A - B. Opcode 3 forms A - B - (1 - C). Opcode 4 forms 0 - B. C is set exactly when no borrow occurs. Example: 0x10 - 0x01 sets C, and negating 0 sets C.
- R3: For opcodes 0 to 6, V (flag bit 0) is set exactly when the true signed result does not fit in the operand width. Example: 0x7FFFFFFF + 1 sets V and leaves C clear.
- R4: For every opcode from 0 to 12, N (flag bit 3) equals the top bit of the result, and Z (flag bit 2) is set exactly when the result is zero.
- R5: The logical opcodes give these results: 7 (test) and 8 give A AND B, 9 gives A OR B, 10 gives A XOR B, 11 gives NOT B, and 12 gives A AND NOT B.
- R6: Opcodes 7 to 12 pass C (flag bit 1) and V (flag bit 0) from the flag register to the next flags unchanged.
- R7: Opcodes 5, 6 and 7 hold the write-back enable low but still produce next flags. Opcodes 0 to 4 and 8 to 12 raise the write-back enable.
- R8: The flag register clears to 0000 on reset. It loads the next flags on a rising edge when flag-write is high, and it holds its value otherwise.
- R9: Opcodes 13 to 15 give a result of zero, hold the write-back enable low, and make the next flags equal the current flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| flag_we_i | input | 1 | Load next flags into the flag register at the next edge |
| result_o | output | WIDTH | Operation result |
| wb_en_o | output | 1 | Destination write-back enable |
| flags_next_o | output | 4 | Next flags {N,Z,C,V} |
| flags_o | output | 4 | Registered flags {N,Z,C,V} |

## Verification
The result, the write-back enable and the next flags are combinational. They are due in the same cycle as the operands and opcode, and they depend only on the flag register's value in that cycle. The registered flags change only at the first rising edge after flag-write is seen high. The bench changes its inputs on the falling edge and reads the combinational outputs a short time later, in the same cycle. It reads the flag register a short time after the following rising edge, and it checks for a fresh load or for no change, depending on the flag-write it drove. A 4-bit instance is swept exhaustively over every opcode, every operand pair and four flag preloads, and a 32-bit instance covers the corner cases named above plus random chains.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_NEG = 4'd4,
        OP_CMP = 4'd5,
        OP_CMN = 4'd6,
        OP_TST = 4'd7,
        OP_AND = 4'd8,
        OP_ORR = 4'd9,
        OP_EOR = 4'd10,
        OP_MVN = 4'd11,
        OP_BIC = 4'd12
    } alu_op_e;

    localparam int FLG_N = 3;
    localparam int FLG_Z = 2;
    localparam int FLG_C = 1;
    localparam int FLG_V = 0;

    localparam logic [3:0] OP_LAST = OP_BIC;

endpackage

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic             inv_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             ovf_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] y_eff;
    logic [WIDTH:0]   wide_sum;

    always_comb begin
        y_eff    = inv_i ? ~y_i : y_i;
        wide_sum = {1'b0, x_i} + {1'b0, y_eff} + {{WIDTH{1'b0}}, cin_i};
        sum_o    = wide_sum[WIDTH-1:0];
        cout_o   = wide_sum[WIDTH];
        ovf_o    = (x_i[MSB] == y_eff[MSB]) && (wide_sum[MSB] != x_i[MSB]);
    end
endmodule

// File: rtl/alu_logic.sv
`timescale 1ns/1ps
module alu_logic
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] res_o
);
    always_comb begin
        case (op_i)
            OP_TST,
            OP_AND:  res_o = a_i & b_i;
            OP_ORR:  res_o = a_i | b_i;
            OP_EOR:  res_o = a_i ^ b_i;
            OP_MVN:  res_o = ~b_i;
            OP_BIC:  res_o = a_i & ~b_i;
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/alu_flag_reg.sv
`timescale 1ns/1ps
module alu_flag_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we_i,
    input  logic [3:0] d_i,
    output logic [3:0] q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= 4'b0000;
        end else if (we_i) begin
            q_o <= d_i;
        end
    end
endmodule

// File: rtl/alu_flags_unit.sv
`timescale 1ns/1ps
module alu_flags_unit
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             flag_we_i,
    output logic [WIDTH-1:0] result_o,
    output logic             wb_en_o,
    output logic [3:0]       flags_next_o,
    output logic [3:0]       flags_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] add_x;
    logic             add_inv;
    logic             add_cin;
    logic             is_arith;
    logic             is_valid;
    logic             wb_en;
    logic [WIDTH-1:0] add_sum;
    logic             add_cout;
    logic             add_ovf;
    logic [WIDTH-1:0] logic_res;
    logic [3:0]       flags_q;

    // Operand steering for the shared adder
    always_comb begin
        add_x    = a_i;
        add_inv  = 1'b0;
        add_cin  = 1'b0;
        is_arith = 1'b1;
        is_valid = 1'b1;
        wb_en    = 1'b1;
        case (op_i)
            OP_ADD: ;
            OP_ADC: add_cin = flags_q[FLG_C];
            OP_SUB: begin
                add_inv = 1'b1;
                add_cin = 1'b1;
            end
            OP_SBC: begin
                add_inv = 1'b1;
                add_cin = flags_q[FLG_C];
            end
            OP_NEG: begin
                add_x   = '0;
                add_inv = 1'b1;
                add_cin = 1'b1;
            end
            OP_CMP: begin
                add_inv = 1'b1;
                add_cin = 1'b1;
                wb_en   = 1'b0;
            end
            OP_CMN: wb_en = 1'b0;
            OP_TST: begin
                is_arith = 1'b0;
                wb_en    = 1'b0;
            end
            OP_AND, OP_ORR, OP_EOR, OP_MVN, OP_BIC: is_arith = 1'b0;
            default: begin
                is_arith = 1'b0;
                is_valid = 1'b0;
                wb_en    = 1'b0;
            end
        endcase
    end

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .x_i    (add_x),
        .y_i    (b_i),
        .inv_i  (add_inv),
        .cin_i  (add_cin),
        .sum_o  (add_sum),
        .cout_o (add_cout),
        .ovf_o  (add_ovf)
    );

    alu_logic #(.WIDTH(WIDTH)) u_logic (
        .op_i  (op_i),
        .a_i   (a_i),
        .b_i   (b_i),
        .res_o (logic_res)
    );

    // Result select and next-flag formation
    always_comb begin
        if (!is_valid) begin
            result_o     = '0;
            flags_next_o = flags_q;
        end else if (is_arith) begin
            result_o     = add_sum;
            flags_next_o = {add_sum[MSB], (add_sum == '0), add_cout, add_ovf};
        end else begin
            result_o     = logic_res;
            flags_next_o = {logic_res[MSB], (logic_res == '0),
                            flags_q[FLG_C], flags_q[FLG_V]};
        end
        wb_en_o = wb_en;
    end

    alu_flag_reg u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (flag_we_i),
        .d_i   (flags_next_o),
        .q_o   (flags_q)
    );

    assign flags_o = flags_q;
endmodule

// File: rtl/alu_flags_chk.sv
`timescale 1ns/1ps
module alu_flags_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       op_i,
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             flag_we_i,
    input logic [WIDTH-1:0] result_o,
    input logic             wb_en_o,
    input logic [3:0]       flags_next_o,
    input logic [3:0]       flags_o
);
    AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd0) |-> ({flags_next_o[1], result_o} == ({1'b0, a_i} + {1'b0, b_i}))); // R1
    AST_N_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i <= 4'd12) |-> (flags_next_o[3] == result_o[WIDTH-1])); // R4
    AST_Z_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i <= 4'd12) |-> (flags_next_o[2] == (result_o == '0))); // R4
    AST_LOGIC_KEEP_CV: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= 4'd7 && op_i <= 4'd12) |-> (flags_next_o[1:0] == flags_o[1:0])); // R6
    AST_CMP_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= 4'd5 && op_i <= 4'd7) |-> !wb_en_o); // R7
    AST_OP_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i <= 4'd4 || (op_i >= 4'd8 && op_i <= 4'd12)) |-> wb_en_o); // R7
    AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we_i |=> (flags_o == $past(flags_next_o))); // R8
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we_i |=> $stable(flags_o)); // R8
    AST_BAD_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i > 4'd12) |-> (result_o == '0 && !wb_en_o && flags_next_o == flags_o)); // R9
endmodule

bind alu_flags_unit alu_flags_chk #(.WIDTH(WIDTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_i         (op_i),
    .a_i          (a_i),
    .b_i          (b_i),
    .flag_we_i    (flag_we_i),
    .result_o     (result_o),
    .wb_en_o      (wb_en_o),
    .flags_next_o (flags_next_o),
    .flags_o      (flags_o)
);

// File: tb/tb_alu_flags_unit.sv
`timescale 1ns/1ps
module tb_alu_flags_unit;
    localparam int NW = 4;
    localparam int WW = 32;

    logic clk = 1'b0;
    always #10 clk = ~clk;
    logic rst_n;

    logic [3:0]    n_op;
    logic [NW-1:0] n_a, n_b, n_res;
    logic          n_we, n_wb;
    logic [3:0]    n_fn, n_fq, n_mf;

    logic [3:0]    w_op;
    logic [WW-1:0] w_a, w_b, w_res;
    logic          w_we, w_wb;
    logic [3:0]    w_fn, w_fq, w_mf;

    int checks = 0;
    int fails  = 0;

    alu_flags_unit #(.WIDTH(NW)) dut (
        .clk(clk), .rst_n(rst_n), .op_i(n_op), .a_i(n_a), .b_i(n_b),
        .flag_we_i(n_we), .result_o(n_res), .wb_en_o(n_wb),
        .flags_next_o(n_fn), .flags_o(n_fq)
    );

    alu_flags_unit #(.WIDTH(WW)) dut_wide (
        .clk(clk), .rst_n(rst_n), .op_i(w_op), .a_i(w_a), .b_i(w_b),
        .flag_we_i(w_we), .result_o(w_res), .wb_en_o(w_wb),
        .flags_next_o(w_fn), .flags_o(w_fq)
    );

    typedef struct packed {
        logic [31:0] res;
        logic        wb;
        logic [3:0]  f;
    } exp_t;

    function automatic exp_t model(int w, logic [3:0] op, logic [31:0] a,
                                   logic [31:0] b, logic [3:0] fl);
        longint mask = (longint'(1) << w) - 1;
        longint ua = longint'(a) & mask;
        longint ub = longint'(b) & mask;
        longint ci = longint'(fl[1]);
        longint sa = ua[w-1] ? ua - (longint'(1) << w) : ua;
        longint sb = ub[w-1] ? ub - (longint'(1) << w) : ub;
        longint lo = -(longint'(1) << (w - 1));
        longint hi = (longint'(1) << (w - 1)) - 1;
        longint r = 0, sg = 0, t;
        logic c = 1'b0;
        logic arith = 1'b1;
        exp_t e;
        e.wb = 1'b1;
        e.f  = fl;
        e.res = '0;
        case (op)
            4'd0, 4'd6: begin t = ua + ub; r = t & mask; c = t[w]; sg = sa + sb; end
            4'd1: begin t = ua + ub + ci; r = t & mask; c = t[w]; sg = sa + sb + ci; end
            4'd2, 4'd5: begin r = (ua - ub) & mask; c = (ua >= ub); sg = sa - sb; end
            4'd3: begin
                r = (ua - ub - (1 - ci)) & mask; c = (ua >= ub + (1 - ci));
                sg = sa - sb - (1 - ci);
            end
            4'd4: begin r = (0 - ub) & mask; c = (ub == 0); sg = -sb; end
            4'd7, 4'd8: begin r = ua & ub; arith = 1'b0; end
            4'd9:  begin r = ua | ub; arith = 1'b0; end
            4'd10: begin r = ua ^ ub; arith = 1'b0; end
            4'd11: begin r = (~ub) & mask; arith = 1'b0; end
            4'd12: begin r = ua & ((~ub) & mask); arith = 1'b0; end
            default: begin e.wb = 1'b0; return e; end
        endcase
        e.res = 32'(r);
        if (arith) e.f = {r[w-1], (r == 0), c, (sg < lo || sg > hi)};
        else       e.f = {r[w-1], (r == 0), fl[1], fl[0]};
        if (op == 4'd5 || op == 4'd6 || op == 4'd7) e.wb = 1'b0;
        return e;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_out(logic [3:0] op, exp_t e, logic [31:0] res, logic wb, logic [3:0] fn);
        string rr, rc, rv;
        if (op <= 4'd1 || op == 4'd6)      begin rr = "R1"; rc = "R1"; rv = "R3"; end
        else if (op <= 4'd5)               begin rr = "R2"; rc = "R2"; rv = "R3"; end
        else if (op <= 4'd12)              begin rr = "R5"; rc = "R6"; rv = "R6"; end
        else                               begin rr = "R9"; rc = "R9"; rv = "R9"; end
        chk(rr, "result", res, e.res);
        chk((op > 4'd12) ? "R9" : "R7", "write-back", 32'(wb), 32'(e.wb));
        chk((op > 4'd12) ? "R9" : "R4", "flag N", 32'(fn[3]), 32'(e.f[3]));
        chk((op > 4'd12) ? "R9" : "R4", "flag Z", 32'(fn[2]), 32'(e.f[2]));
        chk(rc, "flag C", 32'(fn[1]), 32'(e.f[1]));
        chk(rv, "flag V", 32'(fn[0]), 32'(e.f[0]));
    endtask

    task automatic n_step(logic [3:0] op, logic [NW-1:0] a, logic [NW-1:0] b, logic we);
        exp_t e;
        @(negedge clk);
        n_op = op; n_a = a; n_b = b; n_we = we;
        #2;
        e = model(NW, op, 32'(a), 32'(b), n_mf);
        check_out(op, e, 32'(n_res), n_wb, n_fn);
        @(posedge clk);
        #2;
        if (we) n_mf = e.f;
        chk("R8", "narrow flag register", 32'(n_fq), 32'(n_mf));
    endtask

    task automatic w_step(logic [3:0] op, logic [WW-1:0] a, logic [WW-1:0] b, logic we);
        exp_t e;
        @(negedge clk);
        w_op = op; w_a = a; w_b = b; w_we = we;
        #2;
        e = model(WW, op, a, b, w_mf);
        check_out(op, e, w_res, w_wb, w_fn);
        @(posedge clk);
        #2;
        if (we) w_mf = e.f;
        chk("R8", "wide flag register", 32'(w_fq), 32'(w_mf));
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        n_op = '0; n_a = '0; n_b = '0; n_we = 1'b0;
        w_op = '0; w_a = '0; w_b = '0; w_we = 1'b0;
        n_mf = 4'b0000; w_mf = 4'b0000;
        repeat (3) @(posedge clk);
        #2;
        chk("R8", "reset narrow flags", 32'(n_fq), 32'h0);
        chk("R8", "reset wide flags", 32'(w_fq), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R8 hold plus exhaustive sweep under four flag preloads
        for (int p = 0; p < 4; p++) begin
            case (p)
                0: n_step(4'd0, 4'd0, 4'd0, 1'b1);
                1: n_step(4'd5, 4'd0, 4'd0, 1'b1);
                2: n_step(4'd0, 4'd7, 4'd1, 1'b1);
                default: n_step(4'd0, 4'd8, 4'd8, 1'b1);
            endcase
            for (int op = 0; op < 16; op++)
                for (int a = 0; a < 16; a++)
                    for (int b = 0; b < 16; b++)
                        n_step(4'(op), 4'(a), 4'(b), 1'b0);
        end

        // Chained flag loads (R8) feeding carry-in operations (R1, R2)
        for (int i = 0; i < 4096; i++)
            n_step(4'(i), 4'(i / 16), 4'((i * 7 + 3) / 5), 1'b1);

        // Wide corner cases
        w_step(4'd0, 32'h8000_0000, 32'h8000_0000, 1'b1); // R1 carry, R3 overflow
        w_step(4'd2, 32'h0000_0010, 32'h0000_0001, 1'b1); // R2 no borrow
        w_step(4'd0, 32'h7FFF_FFFF, 32'h0000_0001, 1'b1); // R3 V set, C clear
        w_step(4'd4, 32'h1234_5678, 32'h0000_0000, 1'b1); // R2 negate zero
        w_step(4'd4, 32'h0000_0000, 32'h0000_0001, 1'b1); // R2 negate one
        w_step(4'd0, 32'h0, 32'h0, 1'b1);                 // C cleared
        w_step(4'd3, 32'd5, 32'd3, 1'b1);                 // R2 sbc with C=0
        w_step(4'd5, 32'h0, 32'h0, 1'b1);                 // R7 compare, C set
        w_step(4'd1, 32'd1, 32'd1, 1'b0);                 // R1 adc with C=1
        w_step(4'd3, 32'd5, 32'd3, 1'b0);                 // R2 sbc with C=1
        w_step(4'd6, 32'hFFFF_FFFF, 32'h1, 1'b1);         // R7 compare-negative
        w_step(4'd0, 32'h7FFF_FFFF, 32'h1, 1'b1);         // V set for R6
        w_step(4'd7, 32'hF0, 32'h0F, 1'b1);               // R6 test keeps C/V
        w_step(4'd11, 32'h0, 32'h0, 1'b1);                // R5 not
        w_step(4'd12, 32'hFF, 32'h0F, 1'b1);              // R5 bit clear
        w_step(4'd14, 32'hAAAA_5555, 32'h1, 1'b1);        // R9 undefined
        for (int i = 0; i < 1500; i++)
            w_step(4'($urandom_range(0, 15)), $urandom, $urandom, 1'($urandom));

        summary();
        $finish;
    end
endmodule